// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Front-End

This block sits between five interrupt request lines and the sequencer of a small CPU. It keeps the trigger state of each line, applies per-line masks and a global enable, and picks the highest-priority request. Decisions are made only when the CPU raises a strobe at the end of each instruction. An accepted vectored request produces a one-cycle accept pulse with a 16-bit vector address. An accepted request on the non-vectored line instead produces an active-low acknowledge, so that external logic can place an opcode on the data bus.

The five lines, from highest to lowest priority, are:

- a non-maskable line (`req_trap_i`);
- an edge-latched maskable line (`req_e7_i`);
- two level-sensitive maskable lines (`req_l6_i`, `req_l5_i`);
- an external non-vectored line (`req_ext_i`).

A bus-hold request present at the strobe takes the cycle ahead of every interrupt. Pending state survives to the next strobe. The global enable and the masks are changed by plain command pins driven by the sequencer.

Top module: `irq_front`

## Requirements
- R1: After reset the outputs are idle. `take_o`=0, `hold_ack_o`=0, `ext_ack_n_o`=1, `vec_o`=0 and `src_o`=0. The global enable is off, all three masks are set, and both edge latches are clear.
- R2: When several sources are eligible at a strobe, only the highest is accepted. The order is trap (src 0), edge line (src 1), level-6 line (src 2), level-5 line (src 3), external line (src 4).
- R3: The trap line is accepted only if a rising edge has been latched and the line is still high at the strobe. It ignores the masks and the global enable. Its acceptance clears its edge latch, so a line held high is not taken a second time.
- R4: A rising edge on `req_e7_i` is latched, and the line may fall before the strobe. The latch is cleared by reset, by acceptance of src 1, and by a mask write with bit 3 set. A new edge in the same cycle as a clear keeps the latch set.
- R5: The level lines (src 2, src 3, src 4) are eligible only while high at the strobe. A level that falls before the strobe is lost.
- R6: The vector is the restart number times 8. This gives trap 0x0024, src 1 0x003C, src 2 0x0034 and src 3 0x002C. `vec_o` is 0 whenever `take_o` is low or src 4 is taken.
- R7: The global enable gates src 1 to src 4. It is cleared by reset, by `ie_clr_i`, and by any acceptance. It is set only by `ie_set_i`. Acceptance and `ie_clr_i` each override `ie_set_i` in the same cycle.
- R8: Acceptance of src 4 drives `ext_ack_n_o` low for exactly the one cycle in which `take_o` is high, with `src_o`=4 and `vec_o`=0.
- R9: Requests are evaluated only on a clock edge where `sample_i` is high. The result appears on the outputs in the following cycle, as a one-cycle pulse.
- R10: If `hold_req_i` is high at a strobe, `hold_ack_o` pulses in the following cycle and nothing is accepted. The pending trap or other request is served at a later strobe.
- R11: A write (`mask_we_i`) loads the masks. Bit 0 masks src 3, bit 1 masks src 2, bit 2 masks src 1, and bit 3 clears the src 1 latch. A masked source is not accepted, but its latch is kept. Masks do not affect the trap or the external line.
- R12: Only latched edge state is used at a strobe. An edge that arrives on the strobe edge itself is served at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_trap_i | input | 1 | Non-maskable request (edge plus held level) |
| req_e7_i | input | 1 | Edge-latched maskable request |
| req_l6_i | input | 1 | Level-sensitive maskable request, src 2 |
| req_l5_i | input | 1 | Level-sensitive maskable request, src 3 |
| req_ext_i | input | 1 | Non-vectored level request, src 4 |
| sample_i | input | 1 | End-of-instruction evaluation strobe |
| hold_req_i | input | 1 | Bus-hold request, outranks all interrupts |
| ie_set_i | input | 1 | Enable command |
| ie_clr_i | input | 1 | Disable command |
| mask_we_i | input | 1 | Mask write strobe |
| mask_data_i | input | 4 | Mask bits [2:0] and latch clear [3] |
| take_o | output | 1 | Accept pulse |
| vec_o | output | 16 | Vector address of the accepted vectored source |
| src_o | output | 3 | Index of the accepted source |
| ext_ack_n_o | output | 1 | Active-low acknowledge for src 4 |
| hold_ack_o | output | 1 | Hold granted at this strobe |

## Verification
The bench runs a behavioural model next to the design on every clock. It then steers the stimulus at the corners where a wrong design would show:

- A trap line held high after acceptance. A design that forgot to clear the edge latch would take it repeatedly.
- A trap pulse that falls before the strobe. A design that ignored the level would take it.
- Hold and trap pending together. A design that lost the trap would never serve it later.
- An edge on the strobe edge itself, and an enable and a disable command in the same cycle.
- The latch-clear bit and the mask bits in isolation. A design that discarded the latch when the line is masked would miss the request after unmasking.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;

  localparam int unsigned NSRC  = 5;
  localparam int unsigned SRC_W = 3;
  localparam int unsigned HR_W  = 5;

  typedef enum logic [SRC_W-1:0] {
    SRC_TRAP = 3'd0,
    SRC_E7   = 3'd1,
    SRC_L6   = 3'd2,
    SRC_L5   = 3'd3,
    SRC_EXT  = 3'd4
  } src_e;

  // Restart number doubled, so half-numbered restarts stay integral.
  function automatic logic [HR_W-1:0] half_restart(input logic [SRC_W-1:0] s);
    case (s)
      SRC_TRAP: half_restart = 5'd9;
      SRC_E7:   half_restart = 5'd15;
      SRC_L6:   half_restart = 5'd13;
      SRC_L5:   half_restart = 5'd11;
      default:  half_restart = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/irq_edge_catch.sv
module irq_edge_catch #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_q[g] <= 1'b0;
          q[g]      <= 1'b0;
        end else begin
          prev_q[g] <= din[g];
          // A fresh edge outranks a clear in the same cycle.
          q[g]      <= (q[g] & ~clr[g]) | (din[g] & ~prev_q[g]);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl #(
  parameter int unsigned NMASK = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_cmd,
  input  logic             clr_cmd,
  input  logic             accept,
  input  logic             mask_we,
  input  logic [NMASK-1:0] mask_in,
  output logic             ie,
  output logic [NMASK-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      mask <= '1;
    end else begin
      if (accept || clr_cmd) ie <= 1'b0;
      else if (set_cmd)      ie <= 1'b1;
      if (mask_we) mask <= mask_in;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N   = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N:0] above;

  assign above[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_lane
      assign grant[g]   = pend[g] & ~above[g];
      assign above[g+1] = above[g] | pend[g];
    end
  endgenerate

  assign any = above[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (grant[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irq_front_pkg::*;
#(
  parameter int unsigned VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_trap_i,
  input  logic             req_e7_i,
  input  logic             req_l6_i,
  input  logic             req_l5_i,
  input  logic             req_ext_i,
  input  logic             sample_i,
  input  logic             hold_req_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  input  logic             mask_we_i,
  input  logic [3:0]       mask_data_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [2:0]       src_o,
  output logic             ext_ack_n_o,
  output logic             hold_ack_o
);
  localparam int unsigned NMASK = 3;
  localparam int unsigned PAD_W = VEC_W - HR_W - 2;

  logic [1:0]       edge_q, edge_clr;
  logic             ie;
  logic [NMASK-1:0] mask;
  logic [NSRC-1:0]  pend, grant;
  logic             any_pend, decide, accept;
  logic [SRC_W-1:0] win;
  logic [VEC_W-1:0] win_vec;

  // Edge latches: lane 0 = trap, lane 1 = edge-triggered maskable line.
  irq_edge_catch #(.WIDTH(2)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({req_e7_i, req_trap_i}),
    .clr  (edge_clr),
    .q    (edge_q)
  );

  irq_enable_ctl #(.NMASK(NMASK)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_cmd(ie_set_i),
    .clr_cmd(ie_clr_i),
    .accept (accept),
    .mask_we(mask_we_i),
    .mask_in(mask_data_i[NMASK-1:0]),
    .ie     (ie),
    .mask   (mask)
  );

  always_comb begin
    pend[SRC_TRAP] = edge_q[0] & req_trap_i;
    pend[SRC_E7]   = ie & ~mask[2] & edge_q[1];
    pend[SRC_L6]   = ie & ~mask[1] & req_l6_i;
    pend[SRC_L5]   = ie & ~mask[0] & req_l5_i;
    pend[SRC_EXT]  = ie & req_ext_i;
  end

  irq_pick #(.N(NSRC)) u_pick (
    .pend (pend),
    .grant(grant),
    .any  (any_pend),
    .idx  (win)
  );

  assign decide = sample_i & ~hold_req_i;
  assign accept = decide & any_pend;

  assign edge_clr[0] = accept & grant[SRC_TRAP];
  assign edge_clr[1] = (accept & grant[SRC_E7]) | (mask_we_i & mask_data_i[3]);

  assign win_vec = {{PAD_W{1'b0}}, half_restart(win), 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o      <= 1'b0;
      vec_o       <= '0;
      src_o       <= '0;
      ext_ack_n_o <= 1'b1;
      hold_ack_o  <= 1'b0;
    end else begin
      take_o      <= accept;
      src_o       <= accept ? win : '0;
      vec_o       <= (accept && !grant[SRC_EXT]) ? win_vec : '0;
      ext_ack_n_o <= ~(accept & grant[SRC_EXT]);
      hold_ack_o  <= sample_i & hold_req_i;
    end
  end
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_trap_i,
  input logic        sample_i,
  input logic        hold_req_i,
  input logic        take_o,
  input logic [15:0] vec_o,
  input logic [2:0]  src_o,
  input logic        ext_ack_n_o,
  input logic        hold_ack_o
);
  p_take_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(sample_i));

  p_hold_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && hold_req_i) |=> (hold_ack_o && !take_o));

  p_ack_only_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_ack_n_o |-> (take_o && src_o == 3'd4 && vec_o == 16'h0000));

  p_vec_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && ext_ack_n_o) |-> (vec_o[2:0] == 3'b100 && vec_o >= 16'h0024 && vec_o <= 16'h003C));

  p_no_back_to_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

  p_trap_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o == 3'd0) |-> $past(req_trap_i));
endmodule

bind irq_front irq_front_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_trap_i (req_trap_i),
  .sample_i   (sample_i),
  .hold_req_i (hold_req_i),
  .take_o     (take_o),
  .vec_o      (vec_o),
  .src_o      (src_o),
  .ext_ack_n_o(ext_ack_n_o),
  .hold_ack_o (hold_ack_o)
);

// File: tb/irq_front_test.sv
module irq_front_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_trap_i = 0, req_e7_i = 0, req_l6_i = 0, req_l5_i = 0, req_ext_i = 0;
  logic sample_i = 0, hold_req_i = 0, ie_set_i = 0, ie_clr_i = 0, mask_we_i = 0;
  logic [3:0] mask_data_i = 4'h0;
  logic take_o, ext_ack_n_o, hold_ack_o;
  logic [15:0] vec_o;
  logic [2:0] src_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_front uut (
    .clk(clk), .rst_n(rst_n),
    .req_trap_i(req_trap_i), .req_e7_i(req_e7_i), .req_l6_i(req_l6_i),
    .req_l5_i(req_l5_i), .req_ext_i(req_ext_i),
    .sample_i(sample_i), .hold_req_i(hold_req_i),
    .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
    .mask_we_i(mask_we_i), .mask_data_i(mask_data_i),
    .take_o(take_o), .vec_o(vec_o), .src_o(src_o),
    .ext_ack_n_o(ext_ack_n_o), .hold_ack_o(hold_ack_o)
  );

  // Behavioural reference model.
  bit m_ie, m_l7, m_lt, m_p7, m_pt;
  bit [2:0] m_mask;
  bit e_take, e_ackn, e_hold;
  int e_vec, e_src;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ie = 0; m_mask = 3'b111; m_l7 = 0; m_lt = 0; m_p7 = 0; m_pt = 0;
      e_take = 0; e_ackn = 1; e_hold = 0; e_vec = 0; e_src = 0;
    end else begin
      bit acc, acc_t, acc_7;
      acc = 0; acc_t = 0; acc_7 = 0;
      e_take = 0; e_ackn = 1; e_hold = 0; e_vec = 0; e_src = 0;
      if (sample_i) begin
        if (hold_req_i) e_hold = 1;
        else if (m_lt && req_trap_i) begin acc = 1; acc_t = 1; e_src = 0; e_vec = 'h24; end
        else if (m_ie && !m_mask[2] && m_l7) begin acc = 1; acc_7 = 1; e_src = 1; e_vec = 'h3C; end
        else if (m_ie && !m_mask[1] && req_l6_i) begin acc = 1; e_src = 2; e_vec = 'h34; end
        else if (m_ie && !m_mask[0] && req_l5_i) begin acc = 1; e_src = 3; e_vec = 'h2C; end
        else if (m_ie && req_ext_i) begin acc = 1; e_src = 4; e_ackn = 0; end
      end
      e_take = acc;
      if (acc || ie_clr_i) m_ie = 0; else if (ie_set_i) m_ie = 1;
      if (acc_7 || (mask_we_i && mask_data_i[3])) m_l7 = 0;
      if (req_e7_i && !m_p7) m_l7 = 1;
      if (acc_t) m_lt = 0;
      if (req_trap_i && !m_pt) m_lt = 1;
      if (mask_we_i) m_mask = mask_data_i[2:0];
      m_p7 = req_e7_i; m_pt = req_trap_i;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (take_o !== e_take || vec_o !== 16'(e_vec) || src_o !== 3'(e_src) ||
          ext_ack_n_o !== e_ackn || hold_ack_o !== e_hold) begin
        errors++;
        $display("FAIL %s model: act take=%0b vec=%h src=%0d ackn=%0b hold=%0b exp take=%0b vec=%h src=%0d ackn=%0b hold=%0b",
                 phase, take_o, vec_o, src_o, ext_ack_n_o, hold_ack_o,
                 e_take, e_vec, e_src, e_ackn, e_hold);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic strobe();
    sample_i = 1; cyc(); sample_i = 0;
  endtask

  task automatic see_take(input string tag, input int v, input int s, input int ackn);
    chk({tag, " take"}, take_o, 1);
    chk({tag, " vec"}, vec_o, v);
    chk({tag, " src"}, src_o, s);
    chk({tag, " ackn"}, ext_ack_n_o, ackn);
  endtask

  task automatic see_none(input string tag);
    chk({tag, " no take"}, take_o, 0);
  endtask

  task automatic enable();
    ie_set_i = 1; cyc(); ie_set_i = 0;
  endtask

  task automatic setmask(input logic [3:0] d);
    mask_we_i = 1; mask_data_i = d; cyc(); mask_we_i = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL R9 watchdog expired: act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    // R1 reset state
    chk("R1 take", take_o, 0); chk("R1 ackn", ext_ack_n_o, 1);
    chk("R1 hold", hold_ack_o, 0); chk("R1 vec", vec_o, 0);
    req_ext_i = 1; strobe(); see_none("R1 enable off after reset");
    req_ext_i = 0; req_l5_i = 1; enable(); strobe(); see_none("R1 masks set after reset");
    req_l5_i = 0;

    // R2/R5/R6/R7/R8: level sources
    phase = "R2";
    setmask(4'b0000);
    req_l6_i = 1; req_l5_i = 1; req_ext_i = 1;
    strobe(); see_take("R2 level6 over level5 R6", 'h34, 2, 1);
    cyc(); see_none("R9 single pulse");
    phase = "R7";
    strobe(); see_none("R7 enable cleared by accept");
    enable(); strobe(); see_take("R7 re-enabled", 'h34, 2, 1);
    phase = "R5";
    req_l6_i = 0; enable(); strobe(); see_take("R5 level5", 'h2C, 3, 1);
    phase = "R8";
    req_l5_i = 0; enable(); strobe(); see_take("R8 external ack", 0, 4, 0);
    cyc(); chk("R8 ack one cycle", ext_ack_n_o, 1);
    req_ext_i = 0;

    // R9: no strobe, no accept
    phase = "R9";
    req_l5_i = 1; enable();
    repeat (4) begin cyc(); see_none("R9 no strobe"); end
    req_l5_i = 0; strobe(); see_none("R5 level dropped before strobe");

    // R4: edge latch
    phase = "R4";
    req_e7_i = 1; cyc(); req_e7_i = 0; cyc();
    strobe(); see_take("R4 latched edge", 'h3C, 1, 1);
    enable(); strobe(); see_none("R4 latch cleared by accept");
    phase = "R11";
    req_e7_i = 1; cyc(); req_e7_i = 0;
    setmask(4'b1000); strobe(); see_none("R11 clear bit drops latch");
    req_e7_i = 1; cyc(); req_e7_i = 0;
    setmask(4'b0100); strobe(); see_none("R11 masked edge line");
    setmask(4'b0000); strobe(); see_take("R11 latch kept while masked", 'h3C, 1, 1);
    req_ext_i = 1; setmask(4'b0111); enable(); strobe();
    see_take("R11 masks ignore external", 0, 4, 0);
    req_ext_i = 0; setmask(4'b0000);

    // R12: edge on the strobe edge
    phase = "R12";
    enable();
    req_e7_i = 1; sample_i = 1; cyc(); sample_i = 0; req_e7_i = 0;
    see_none("R12 same-edge not yet latched");
    strobe(); see_take("R12 served next strobe", 'h3C, 1, 1);

    // R3: trap
    phase = "R3";
    ie_clr_i = 1; cyc(); ie_clr_i = 0;
    req_trap_i = 1; cyc();
    strobe(); see_take("R3 trap ignores enable", 'h24, 0, 1);
    strobe(); see_none("R3 held trap not retaken");
    req_trap_i = 0; cyc(); req_trap_i = 1; cyc(); req_trap_i = 0; cyc();
    strobe(); see_none("R3 trap needs held level");

    // R10: hold over trap
    phase = "R10";
    req_trap_i = 1; cyc();
    hold_req_i = 1; strobe(); hold_req_i = 0;
    chk("R10 hold ack", hold_ack_o, 1); see_none("R10 trap deferred");
    strobe(); see_take("R10 trap after hold", 'h24, 0, 1);
    req_trap_i = 0; cyc();

    // R2: trap over edge line
    phase = "R2";
    enable(); req_e7_i = 1; req_trap_i = 1; cyc(); req_e7_i = 0;
    strobe(); see_take("R2 trap first", 'h24, 0, 1);
    enable(); strobe(); see_take("R2 edge line next", 'h3C, 1, 1);
    req_trap_i = 0;

    // R7: disable beats enable
    phase = "R7";
    req_l5_i = 1; ie_set_i = 1; ie_clr_i = 1; cyc(); ie_set_i = 0; ie_clr_i = 0;
    strobe(); see_none("R7 disable wins");
    req_l5_i = 0; cyc();

    done = 1;
    summary();
    $finish;
  end
endmodule